// File: doc/BRIEF.md
# Byte-Wide Memory Interface Unit

This unit connects a microcoded datapath to one byte-wide memory that holds instructions, data and stack alike, reached through a 16-bit address. The datapath loads the high address byte and the write byte with ordinary destination codes. Writing the low address byte with a read command or with a write command loads that byte and also starts a memory access. Every access lasts exactly two cycles, and the unit reports it on a busy output.

On a read, the memory's byte is held inside the unit. In the second access cycle the microcode selects where that byte goes: the data register only, the data register and the low address byte, or those two and the instruction register as well. Loading the low address byte from memory lets a pointer be followed without going through the ALU. The address bytes, the data register and the instruction register are all outputs, so the datapath can read them as sources, for example to step the address through the ALU when an operand spans several bytes.

At the start of an access the unit copies the full address and the write byte. Later updates to the high byte or to the write byte therefore do not disturb an access that is already running. A trigger that arrives while an access is running is dropped and sets a sticky error flag.

Top module: `mem_port_unit`

## Requirements
- R1: After reset, `addrHi`, `addrLo`, `mdData`, `irData`, `memAddr` and `memWrData` are all zero, and `busy`, `errFlag` and `memWe` are low.
- R2: Destination code 10 loads `aluData` into the high address byte, which is visible on `addrHi` the next cycle. Destination code 15 loads `aluData` into the write byte. Neither code starts an access: `busy` stays low and no write strobe occurs.
- R3: Destination code 11 with `busy` low loads `aluData` into the low address byte and starts a read. `busy` is high for the next two cycles, then low. During both cycles `memRe` is high and `memAddr` equals {high byte, new low byte}.
- R4: The `memDest` value applied in the second cycle of a read places the byte that memory returned at `memAddr`. The codes are: 1 loads `mdData`; 2 loads `mdData` and `addrLo`; 3 loads `mdData`, `addrLo` and `irData`.
- R5: Destination code 13 with `busy` low loads the low address byte and starts a write. `memWe` is high for exactly one cycle, the second access cycle, with `memAddr` = {high byte, low byte} and `memWrData` = the write byte held at the trigger. `memRe` stays low.
- R6: Writing the high address byte or the write byte during an access changes neither `memAddr` nor the data of that access. The new high byte still appears on `addrHi`.
- R7: A trigger (code 11 or 13) while `busy` is high is ignored. `addrLo` keeps its value and no further access or write strobe occurs. The trigger sets `errFlag`, which stays high until reset.
- R8: `memDest` code 0 in the second read cycle leaves `mdData`, `irData` and `addrLo` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| destSel | input | 4 | ALU destination code of the current control word |
| aluData | input | 8 | ALU result byte |
| memDest | input | 2 | Selects which registers capture the memory byte |
| memRdData | input | 8 | Byte returned by memory for `memAddr` |
| memAddr | output | 16 | Address of the running access |
| memWrData | output | 8 | Write byte of the running access |
| memWe | output | 1 | One-cycle write strobe |
| memRe | output | 1 | High during read access cycles |
| busy | output | 1 | High during the two access cycles |
| errFlag | output | 1 | Sticky flag for a trigger dropped while busy |
| addrHi | output | 8 | High address byte, datapath source |
| addrLo | output | 8 | Low address byte, datapath source |
| mdData | output | 8 | Memory data register |
| irData | output | 8 | Instruction register |

## Verification
The bench builds the unit with its defaults: a 16-bit address, an 8-bit data byte and a two-cycle access. This lets it read addresses whose high byte is all zeros, all ones, or neither, and check every capture selection against a computed memory image. With a two-cycle access, the bench can place a second trigger and updates to the high byte and the write byte inside a running access, and then check that the bus address and the written byte stay fixed.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

  localparam int unsigned DEST_W = 4;

  localparam logic [DEST_W-1:0] DST_ADDR_HI  = 4'd10;
  localparam logic [DEST_W-1:0] DST_LO_READ  = 4'd11;
  localparam logic [DEST_W-1:0] DST_LO_WRITE = 4'd13;
  localparam logic [DEST_W-1:0] DST_WDATA    = 4'd15;

  localparam logic [1:0] CAP_NONE  = 2'd0;
  localparam logic [1:0] CAP_MD    = 2'd1;
  localparam logic [1:0] CAP_MD_LO = 2'd2;
  localparam logic [1:0] CAP_ALL   = 2'd3;

  typedef struct packed {
    logic ldHi;
    logic ldMw;
    logic ldLo;
    logic startAcc;
    logic latchBus;
    logic capMd;
    logic capLo;
    logic capIr;
  } ctlStrobes_t;

endpackage

// File: rtl/mpu_ctrl.sv
module mpu_ctrl
  import mpu_pkg::*;
#(
  parameter int unsigned ACC_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DEST_W-1:0] destSel,
  input  logic [1:0]        memDest,
  output ctlStrobes_t       ctl,
  output logic              busy,
  output logic              errFlag,
  output logic              memWe,
  output logic              memRe
);

  localparam int unsigned CNT_W = $clog2(ACC_CYC + 1);

  logic [CNT_W-1:0] cycLeft;
  logic             isWrite;
  logic             trigger;
  logic             accept;

  assign trigger = (destSel == DST_LO_READ) || (destSel == DST_LO_WRITE);
  assign busy    = (cycLeft != '0);
  assign accept  = trigger && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycLeft <= '0;
      isWrite <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      if (accept) begin
        cycLeft <= CNT_W'(ACC_CYC);
        isWrite <= (destSel == DST_LO_WRITE);
      end else if (busy) begin
        cycLeft <= cycLeft - 1'b1;
      end
      if (trigger && busy) errFlag <= 1'b1;
    end
  end

  assign memWe = busy && isWrite && (cycLeft == CNT_W'(1));
  assign memRe = busy && !isWrite;

  always_comb begin
    ctl          = '0;
    ctl.ldHi     = (destSel == DST_ADDR_HI);
    ctl.ldMw     = (destSel == DST_WDATA);
    ctl.ldLo     = accept;
    ctl.startAcc = accept;
    ctl.latchBus = memRe;
    ctl.capMd    = (memDest != CAP_NONE);
    ctl.capLo    = (memDest == CAP_MD_LO) || (memDest == CAP_ALL);
    ctl.capIr    = (memDest == CAP_ALL);
  end

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> busy);

  // R5
  we_in_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (busy && !memRe));

  // R5
  we_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);

  // R7
  err_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trigger && busy) |=> errFlag);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

endmodule

// File: rtl/mpu_dpath.sv
module mpu_dpath
  import mpu_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [DATA_W-1:0] aluData,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic [DATA_W-1:0] addrLo,
  output logic [DATA_W-1:0] mdData,
  output logic [DATA_W-1:0] irData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData
);

  localparam int unsigned HI_W = ADDR_W - DATA_W;

  logic [HI_W-1:0]   hiReg;
  logic [DATA_W-1:0] loReg;
  logic [DATA_W-1:0] mwReg;
  logic [DATA_W-1:0] mdReg;
  logic [DATA_W-1:0] irReg;
  logic [DATA_W-1:0] busReg;
  logic [ADDR_W-1:0] accAddr;
  logic [DATA_W-1:0] accData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiReg   <= '0;
      loReg   <= '0;
      mwReg   <= '0;
      mdReg   <= '0;
      irReg   <= '0;
      busReg  <= '0;
      accAddr <= '0;
      accData <= '0;
    end else begin
      if (ctl.ldHi) hiReg <= aluData[HI_W-1:0];
      if (ctl.ldMw) mwReg <= aluData;
      if (ctl.ldLo)       loReg <= aluData;
      else if (ctl.capLo) loReg <= busReg;
      if (ctl.capMd) mdReg <= busReg;
      if (ctl.capIr) irReg <= busReg;
      if (ctl.latchBus) busReg <= memRdData;
      if (ctl.startAcc) begin
        accAddr <= {hiReg, aluData};
        accData <= mwReg;
      end
    end
  end

  assign addrHi    = hiReg;
  assign addrLo    = loReg;
  assign mdData    = mdReg;
  assign irData    = irReg;
  assign memAddr   = accAddr;
  assign memWrData = accData;

endmodule

// File: rtl/mem_port_unit.sv
module mem_port_unit
  import mpu_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ACC_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        destSel,
  input  logic [DATA_W-1:0] aluData,
  input  logic [1:0]        memDest,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              memWe,
  output logic              memRe,
  output logic              busy,
  output logic              errFlag,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic [DATA_W-1:0] addrLo,
  output logic [DATA_W-1:0] mdData,
  output logic [DATA_W-1:0] irData
);

  ctlStrobes_t ctl;

  mpu_ctrl #(.ACC_CYC(ACC_CYC)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .destSel (destSel),
    .memDest (memDest),
    .ctl     (ctl),
    .busy    (busy),
    .errFlag (errFlag),
    .memWe   (memWe),
    .memRe   (memRe)
  );

  mpu_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .aluData   (aluData),
    .memRdData (memRdData),
    .addrHi    (addrHi),
    .addrLo    (addrLo),
    .mdData    (mdData),
    .irData    (irData),
    .memAddr   (memAddr),
    .memWrData (memWrData)
  );

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(memAddr) && $stable(memWrData)));

endmodule

// File: tb/test_mem_port_unit.sv
module test_mem_port_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  destSel = 4'd0;
  logic [7:0]  aluData = 8'd0;
  logic [1:0]  memDest = 2'd0;
  logic [7:0]  memRdData;
  logic [15:0] memAddr;
  logic [7:0]  memWrData;
  logic        memWe, memRe, busy, errFlag;
  logic [7:0]  addrHi, addrLo, mdData, irData;

  int nChecks = 0;
  int nFail = 0;
  int weCount = 0;
  logic [15:0] lastWa = 16'd0;
  logic [7:0]  lastWd = 8'd0;

  always #2 clk = ~clk;

  mem_port_unit i_mem_port_unit (
    .clk(clk), .rstN(rstN), .destSel(destSel), .aluData(aluData),
    .memDest(memDest), .memRdData(memRdData), .memAddr(memAddr),
    .memWrData(memWrData), .memWe(memWe), .memRe(memRe), .busy(busy),
    .errFlag(errFlag), .addrHi(addrHi), .addrLo(addrLo),
    .mdData(mdData), .irData(irData)
  );

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return (a[15:8] * 8'd7 + a[7:0]) ^ 8'hA5;
  endfunction

  assign memRdData = memByte(memAddr);

  always @(posedge clk) begin
    if (memWe) begin
      weCount <= weCount + 1;
      lastWa  <= memAddr;
      lastWd  <= memWrData;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic stepDest(input logic [3:0] d, input logic [7:0] v);
    destSel = d; aluData = v;
    @(negedge clk);
    destSel = 4'd0;
  endtask

  localparam int NVEC = 8;
  localparam logic [17:0] VEC [NVEC] = '{
    {8'h00, 8'h00, 2'd3}, {8'hFF, 8'hFF, 2'd1}, {8'h12, 8'h34, 2'd2},
    {8'h80, 8'h01, 2'd0}, {8'h7F, 8'hFE, 2'd3}, {8'hA5, 8'h5A, 2'd2},
    {8'h01, 8'h80, 2'd1}, {8'hC3, 8'h3C, 2'd3}
  };

  initial begin
    #(200000 * 4);
    nFail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [7:0] expMd, expIr, b;
    int we0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 addrHi", {8'd0, addrHi}, 16'd0);
    chk("R1 addrLo", {8'd0, addrLo}, 16'd0);
    chk("R1 md", {8'd0, mdData}, 16'd0);
    chk("R1 ir", {8'd0, irData}, 16'd0);
    chk("R1 memAddr", memAddr, 16'd0);
    chk("R1 flags", {13'd0, busy, errFlag, memWe}, 16'd0);

    // R3 R4 R8 read vectors
    expMd = 8'd0; expIr = 8'd0;
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] hi, lo;
      logic [1:0] sel;
      {hi, lo, sel} = VEC[i];
      stepDest(4'd10, hi);
      destSel = 4'd11; aluData = lo;
      @(negedge clk);
      destSel = 4'd0;
      chk("R3 busy1", {14'd0, busy, memRe}, 16'd3);
      chk("R3 memAddr", memAddr, {hi, lo});
      @(negedge clk);
      chk("R3 busy2", {14'd0, busy, memRe}, 16'd3);
      memDest = sel;
      @(negedge clk);
      memDest = 2'd0;
      chk("R3 busy end", {15'd0, busy}, 16'd0);
      b = memByte({hi, lo});
      if (sel != 2'd0) expMd = b;
      if (sel == 2'd3) expIr = b;
      chk("R4 R8 md", {8'd0, mdData}, {8'd0, expMd});
      chk("R4 R8 lo", {8'd0, addrLo}, {8'd0, (sel >= 2'd2) ? b : lo});
      chk("R4 R8 ir", {8'd0, irData}, {8'd0, expIr});
    end

    // R2 high byte and write byte loads start nothing
    we0 = weCount;
    stepDest(4'd10, 8'h3C);
    chk("R2 addrHi", {8'd0, addrHi}, 16'h003C);
    chk("R2 no busy hi", {15'd0, busy}, 16'd0);
    stepDest(4'd15, 8'h9E);
    chk("R2 no busy mw", {15'd0, busy}, 16'd0);
    @(negedge clk);
    chk("R2 no strobe", 16'(weCount - we0), 16'd0);

    // R5 write access
    stepDest(4'd10, 8'h12);
    destSel = 4'd13; aluData = 8'h34;
    @(negedge clk);
    destSel = 4'd0;
    chk("R5 first cycle", {13'd0, busy, memWe, memRe}, 16'd4);
    @(negedge clk);
    chk("R5 strobe", {13'd0, busy, memWe, memRe}, 16'd6);
    chk("R5 addr", memAddr, 16'h1234);
    chk("R5 data", {8'd0, memWrData}, 16'h009E);
    @(negedge clk);
    chk("R5 strobe end", {14'd0, busy, memWe}, 16'd0);
    chk("R5 count", 16'(weCount - we0), 16'd1);

    // R6 updates during an access do not disturb it
    destSel = 4'd13; aluData = 8'h56;
    @(negedge clk);
    stepDest(4'd10, 8'hFF);
    destSel = 4'd15; aluData = 8'h11;
    chk("R6 addr held", memAddr, 16'h1256);
    @(negedge clk);
    destSel = 4'd0;
    @(negedge clk);
    chk("R6 written addr", lastWa, 16'h1256);
    chk("R6 written data", {8'd0, lastWd}, 16'h009E);
    chk("R6 addrHi updated", {8'd0, addrHi}, 16'h00FF);

    // R7 trigger while busy
    we0 = weCount;
    chk("R7 err before", {15'd0, errFlag}, 16'd0);
    destSel = 4'd11; aluData = 8'h10;
    @(negedge clk);
    destSel = 4'd13; aluData = 8'hEE;
    @(negedge clk);
    destSel = 4'd0;
    chk("R7 err set", {15'd0, errFlag}, 16'd1);
    chk("R7 lo kept", {8'd0, addrLo}, 16'h0010);
    repeat (4) @(negedge clk);
    chk("R7 no write", 16'(weCount - we0), 16'd0);
    chk("R7 idle", {15'd0, busy}, 16'd0);
    chk("R7 err sticky", {15'd0, errFlag}, 16'd1);

    // R1 reset clears everything again
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    chk("R1 err cleared", {14'd0, errFlag, busy}, 16'd0);
    chk("R1 regs cleared", {addrHi, addrLo}, 16'd0);
    chk("R1 md ir cleared", {mdData, irData}, 16'd0);
    chk("R1 bus cleared", memAddr, 16'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule